// File: doc/BRIEF.md
# Serial Character Transmitter with Deferred Shutdown

This block turns host-written characters into an asynchronous serial bit stream. A single holding register sits in front of a frame shift register, so the host can queue the next character while the current one is still on the line. The frame shape is chosen at run time: 5, 6, 7, 8 or 9 data bits, no parity or even or odd parity, and one or two stop bits. Bit timing comes from an external `baud_tick` strobe, with one line bit per tick interval.

Clearing the transmit enable does not cut a frame short. The block keeps driving the line until the holding register and the shift register are both empty, and only then releases the pin. Two status flags are provided: holding register empty, and transmission finished. Each flag has its own interrupt enable. The ninth data bit has its own write strobe, and the low-byte write commits the whole character.

Top module: `tx_gd`

## Requirements
- R1: After reset `txd` is 1, `tx_drive` is 0, `buf_empty` is 1 and `tx_done` is 0.
- R2: A frame is a 0 start bit, then the data bits least significant first, then an optional parity bit, then stop bits of value 1. Each bit lasts from one `baud_tick` to the next. A frame starts on the first tick at which the holding register is full and the shifter is idle or is finishing its last stop bit. An idle line is 1.
- R3: `char_size` selects the data width: 000=5, 001=6, 010=7, 011=8, 111=9. The other codes select 8. The width is sampled when the character enters the shifter.
- R4: `par_mode` 10 appends an even parity bit and 11 an odd parity bit, computed over the data bits actually sent. Codes 00 and 01 append none.
- R5: `two_stop`=0 gives one stop bit and `two_stop`=1 gives two.
- R6: A `wr_hi` strobe stores `hi_bit`. A later `wr_lo` commits `{stored hi_bit, wr_data}`, and the stored bit is sent as data bit 8 in 9-bit frames.
- R7: A committed write clears `buf_empty` on the next edge. It sets again on the edge where the character moves into the shifter. A `wr_lo` while the holding register is full is ignored.
- R8: `tx_done` sets on the edge where the last stop bit ends with no character waiting. A commit clears it, and a commit wins if both happen on the same edge.
- R9: `irq_empty` is `ie_empty` AND `buf_empty`. `irq_done` is `ie_done` AND `tx_done`.
- R10: When `tx_enable` falls, `tx_drive` stays 1 until the holding register and the shifter are both empty. Whenever `tx_drive` is 0, `txd` is 1.
- R11: A `wr_lo` while `tx_drive` is 0 is ignored. A write made during the drain accepted in R10 is still sent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| baud_tick | input | 1 | One-cycle strobe marking each bit boundary |
| tx_enable | input | 1 | Transmit enable; a clear is deferred until drained |
| char_size | input | 3 | Data width code |
| par_mode | input | 2 | Parity mode code |
| two_stop | input | 1 | Two stop bits when 1 |
| wr_hi | input | 1 | Store `hi_bit` as the ninth data bit |
| hi_bit | input | 1 | Ninth data bit value |
| wr_lo | input | 1 | Commit a character with `wr_data` as its low bits |
| wr_data | input | 8 | Low data bits |
| ie_empty | input | 1 | Interrupt enable for the empty flag |
| ie_done | input | 1 | Interrupt enable for the finished flag |
| txd | output | 1 | Serial line |
| tx_drive | output | 1 | Block owns the pin |
| buf_empty | output | 1 | Holding register empty |
| tx_done | output | 1 | Transmission finished, nothing pending |
| irq_empty | output | 1 | Empty interrupt |
| irq_done | output | 1 | Finished interrupt |

## Verification
The bench builds the block with its default nine-bit maximum and a 13-bit frame vector, so every width code and both parity polarities can be used. It pulses `baud_tick` every third clock. This short interval makes it possible to commit a character on the same edge a stop bit ends, to queue a character behind one that is still shifting, and to attempt an overwrite while the buffer is full. Halting the tick holds the buffer full on purpose, which makes the ignored-write case deterministic. The deferred shutdown is tested by dropping the enable with two characters still queued.

// File: rtl/tx_gd_pkg.sv
package tx_gd_pkg;
  typedef enum logic [1:0] {
    PAR_NONE = 2'b00,
    PAR_RSVD = 2'b01,
    PAR_EVEN = 2'b10,
    PAR_ODD  = 2'b11
  } par_mode_e;

  function automatic int unsigned data_bits(input logic [2:0] code);
    case (code)
      3'b000:  data_bits = 5;
      3'b001:  data_bits = 6;
      3'b010:  data_bits = 7;
      3'b111:  data_bits = 9;
      default: data_bits = 8;
    endcase
  endfunction
endpackage

// File: rtl/tx_gd_holding.sv
module tx_gd_holding #(
  parameter int DW = 9,
  localparam int LW = DW - 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_hi,
  input  logic          hi_bit,
  input  logic          wr_lo,
  input  logic [LW-1:0] lo_data,
  input  logic          accept,
  input  logic          load,
  output logic          commit,
  output logic          full,
  output logic          full_nxt,
  output logic [DW-1:0] data
);
  logic          hi_q;
  logic [DW-1:0] data_nxt;

  always_comb begin
    commit   = wr_lo && !full && accept;
    full_nxt = full;
    data_nxt = data;
    if (commit) begin
      full_nxt = 1'b1;
      data_nxt = {hi_q, lo_data};
    end else if (load) begin
      full_nxt = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_q <= 1'b0;
      full <= 1'b0;
      data <= '0;
    end else begin
      if (wr_hi) hi_q <= hi_bit;
      full <= full_nxt;
      if (commit) data <= data_nxt;
    end
  end
endmodule

// File: rtl/tx_gd_framer.sv
module tx_gd_framer
  import tx_gd_pkg::*;
#(
  parameter int DW = 9,
  parameter int FW = DW + 4,
  localparam int CW = $clog2(FW + 1)
) (
  input  logic [DW-1:0] data,
  input  logic [2:0]    char_size,
  input  logic [1:0]    par_mode,
  input  logic          two_stop,
  output logic [FW-1:0] frame,
  output logic [CW-1:0] nbits
);
  int   n;
  logic pen;
  logic par;

  always_comb begin
    n     = int'(data_bits(char_size));
    pen   = (par_mode == PAR_EVEN) || (par_mode == PAR_ODD);
    par   = (par_mode == PAR_ODD);
    frame = '1;
    frame[0] = 1'b0;
    for (int i = 0; i < DW; i++) begin
      if (i < n) begin
        frame[1+i] = data[i];
        par = par ^ data[i];
      end else if (i == n && pen) begin
        frame[1+i] = par;
      end
    end
    if (pen && n == DW) frame[1+DW] = par;
    nbits = CW'(2 + n + int'(pen) + int'(two_stop));
  end
endmodule

// File: rtl/tx_gd_shifter.sv
module tx_gd_shifter #(
  parameter int FW = 13,
  localparam int CW = $clog2(FW + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          pend,
  input  logic [FW-1:0] frame,
  input  logic [CW-1:0] nbits,
  output logic          load,
  output logic          finish,
  output logic          busy,
  output logic          busy_nxt,
  output logic          line
);
  logic [FW-1:0] sh, sh_nxt;
  logic [CW-1:0] cnt, cnt_nxt;
  logic          last;
  logic          adv;

  always_comb begin
    last     = busy && (cnt == CW'(1));
    load     = tick && pend && (!busy || last);
    finish   = tick && last && !pend;
    adv      = load || (tick && busy);
    sh_nxt   = sh;
    cnt_nxt  = cnt;
    busy_nxt = busy;
    if (load) begin
      sh_nxt   = frame;
      cnt_nxt  = nbits;
      busy_nxt = 1'b1;
    end else if (tick && busy) begin
      if (last) begin
        busy_nxt = 1'b0;
      end else begin
        sh_nxt  = {1'b1, sh[FW-1:1]};
        cnt_nxt = cnt - CW'(1);
      end
    end
    line = busy ? sh[0] : 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh   <= '1;
      cnt  <= '0;
      busy <= 1'b0;
    end else if (adv) begin
      sh   <= sh_nxt;
      cnt  <= cnt_nxt;
      busy <= busy_nxt;
    end
  end
endmodule

// File: rtl/tx_gd.sv
module tx_gd #(
  parameter int DATA_MAX = 9,
  localparam int LW = DATA_MAX - 1,
  localparam int FW = DATA_MAX + 4,
  localparam int CW = $clog2(FW + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          baud_tick,
  input  logic          tx_enable,
  input  logic [2:0]    char_size,
  input  logic [1:0]    par_mode,
  input  logic          two_stop,
  input  logic          wr_hi,
  input  logic          hi_bit,
  input  logic          wr_lo,
  input  logic [LW-1:0] wr_data,
  input  logic          ie_empty,
  input  logic          ie_done,
  output logic          txd,
  output logic          tx_drive,
  output logic          buf_empty,
  output logic          tx_done,
  output logic          irq_empty,
  output logic          irq_done
);
  logic                commit, full, full_nxt, load, finish, busy, busy_nxt, line;
  logic [DATA_MAX-1:0] hold_data;
  logic [FW-1:0]       frame;
  logic [CW-1:0]       nbits;
  logic                active, active_nxt, done_nxt;

  tx_gd_holding #(.DW(DATA_MAX)) u_hold (
    .clk(clk), .rst_n(rst_n), .wr_hi(wr_hi), .hi_bit(hi_bit), .wr_lo(wr_lo),
    .lo_data(wr_data), .accept(active), .load(load), .commit(commit),
    .full(full), .full_nxt(full_nxt), .data(hold_data)
  );

  tx_gd_framer #(.DW(DATA_MAX), .FW(FW)) u_frm (
    .data(hold_data), .char_size(char_size), .par_mode(par_mode),
    .two_stop(two_stop), .frame(frame), .nbits(nbits)
  );

  tx_gd_shifter #(.FW(FW)) u_shf (
    .clk(clk), .rst_n(rst_n), .tick(baud_tick), .pend(full), .frame(frame),
    .nbits(nbits), .load(load), .finish(finish), .busy(busy),
    .busy_nxt(busy_nxt), .line(line)
  );

  always_comb begin
    active_nxt = tx_enable || (active && (full_nxt || busy_nxt));
    done_nxt   = tx_done;
    if (commit)      done_nxt = 1'b0;
    else if (finish) done_nxt = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active  <= 1'b0;
      tx_done <= 1'b0;
    end else begin
      active  <= active_nxt;
      tx_done <= done_nxt;
    end
  end

  assign tx_drive  = active;
  assign txd       = active ? line : 1'b1;
  assign buf_empty = !full;
  assign irq_empty = ie_empty && buf_empty;
  assign irq_done  = ie_done && tx_done;
endmodule

// File: rtl/tx_gd_chk.sv
module tx_gd_chk (
  input logic clk,
  input logic rst_n,
  input logic baud_tick,
  input logic tx_enable,
  input logic wr_lo,
  input logic ie_empty,
  input logic txd,
  input logic tx_drive,
  input logic buf_empty,
  input logic tx_done,
  input logic irq_empty
);
  a_r10_idle_high: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_drive |-> txd);
  a_r10_hold_drive: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_drive && !tx_enable && !buf_empty) |=> tx_drive);
  a_r7_fill_by_write: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(buf_empty) |-> $past(wr_lo));
  a_r2_load_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(buf_empty) |-> $past(baud_tick));
  a_r8_clear_by_write: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(tx_done) |-> $past(wr_lo));
  a_r9_empty_irq_gated: assert property (@(posedge clk) disable iff (!rst_n)
    irq_empty |-> (ie_empty && buf_empty));
  a_r11_closed_ignore: assert property (@(posedge clk) disable iff (!rst_n)
    (!tx_drive && !tx_enable && wr_lo && buf_empty) |=> buf_empty);
endmodule

bind tx_gd tx_gd_chk u_chk (
  .clk(clk), .rst_n(rst_n), .baud_tick(baud_tick), .tx_enable(tx_enable),
  .wr_lo(wr_lo), .ie_empty(ie_empty), .txd(txd), .tx_drive(tx_drive),
  .buf_empty(buf_empty), .tx_done(tx_done), .irq_empty(irq_empty)
);

// File: tb/tb_tx_gd.sv
`timescale 1ns/1ps
module tb_tx_gd;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       baud_tick = 1'b0, tx_enable = 1'b0, two_stop = 1'b0;
  logic [2:0] char_size = 3'b011;
  logic [1:0] par_mode = 2'b00;
  logic       wr_hi = 1'b0, hi_bit = 1'b0, wr_lo = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic       ie_empty = 1'b0, ie_done = 1'b0;
  logic       txd, tx_drive, buf_empty, tx_done, irq_empty, irq_done;

  int total = 0, bad = 0;
  bit tick_on = 1'b0;
  int tick_cnt = 0;

  always #2 clk = ~clk;

  tx_gd dut (
    .clk(clk), .rst_n(rst_n), .baud_tick(baud_tick), .tx_enable(tx_enable),
    .char_size(char_size), .par_mode(par_mode), .two_stop(two_stop),
    .wr_hi(wr_hi), .hi_bit(hi_bit), .wr_lo(wr_lo), .wr_data(wr_data),
    .ie_empty(ie_empty), .ie_done(ie_done), .txd(txd), .tx_drive(tx_drive),
    .buf_empty(buf_empty), .tx_done(tx_done), .irq_empty(irq_empty),
    .irq_done(irq_done)
  );

  // reference model state
  bit   m_active, m_full, m_busy, m_done, m_cur, m_b8;
  bit   q[$];
  logic [8:0] m_data;

  function automatic int width_of(input logic [2:0] c);
    case (c)
      3'b000: return 5;
      3'b001: return 6;
      3'b010: return 7;
      3'b111: return 9;
      default: return 8;
    endcase
  endfunction

  task automatic build_frame(input logic [8:0] d);
    int n;
    bit p;
    n = width_of(char_size);
    p = (par_mode == 2'b11);
    q.delete();
    q.push_back(1'b0);
    for (int i = 0; i < n; i++) begin
      q.push_back(d[i]);
      p ^= d[i];
    end
    if (par_mode[1]) q.push_back(p);
    q.push_back(1'b1);
    if (two_stop) q.push_back(1'b1);
  endtask

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_active = 0; m_full = 0; m_busy = 0; m_done = 0; m_cur = 1; m_b8 = 0;
      m_data = '0; q.delete();
    end else begin
      bit last, ld, cm, fin, old_b8;
      last   = m_busy && (q.size() == 0);
      ld     = baud_tick && m_full && (!m_busy || last);
      cm     = wr_lo && !m_full && m_active;
      fin    = baud_tick && last && !m_full;
      old_b8 = m_b8;
      if (wr_hi) m_b8 = hi_bit;
      if (ld) begin
        build_frame(m_data);
        m_cur  = q.pop_front();
        m_busy = 1;
      end else if (baud_tick && m_busy) begin
        if (last) m_busy = 0;
        else m_cur = q.pop_front();
      end
      if (cm) begin
        m_full = 1;
        m_data = {old_b8, wr_data};
      end else if (ld) m_full = 0;
      if (cm) m_done = 0;
      else if (fin) m_done = 1;
      m_active = tx_enable || (m_active && (m_full || m_busy));
    end
  end

  task automatic check(input string req, input logic act, input logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s at %0t: actual=%0b expected=%0b", req, $time, act, exp);
    end
  endtask

  // compare every cycle, away from the edges
  always @(negedge clk) begin
    #1;
    if (rst_n) begin
      check("R2 R3 R4 R5 R6 txd", txd, (m_active && m_busy) ? m_cur : 1'b1);
      check("R10 tx_drive", tx_drive, m_active);
      check("R7 buf_empty", buf_empty, !m_full);
      check("R8 tx_done", tx_done, m_done);
      check("R9 irq_empty", irq_empty, ie_empty && !m_full);
      check("R9 irq_done", irq_done, ie_done && m_done);
    end
  end

  // baud tick generator: one pulse every third cycle while enabled
  always @(negedge clk) begin
    if (tick_on) begin
      tick_cnt  = (tick_cnt == 2) ? 0 : tick_cnt + 1;
      baud_tick <= (tick_cnt == 0);
    end else begin
      baud_tick <= 1'b0;
    end
  end

  task automatic put(input logic [7:0] lo, input logic b8);
    @(negedge clk); wr_hi = 1'b1; hi_bit = b8;
    @(negedge clk); wr_hi = 1'b0; wr_lo = 1'b1; wr_data = lo;
    @(negedge clk); wr_lo = 1'b0;
  endtask

  task automatic drain();
    for (int k = 0; k < 400; k++) begin
      @(negedge clk);
      if (!m_busy && !m_full) break;
    end
    repeat (4) @(negedge clk);
  endtask

  task automatic frame_cfg(input logic [2:0] cs, input logic [1:0] pm, input logic ts);
    @(negedge clk); char_size = cs; par_mode = pm; two_stop = ts;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    #1;
    total++; if (!(txd === 1'b1 && tx_drive === 1'b0 && buf_empty === 1'b1 && tx_done === 1'b0)) begin
      bad++; $display("FAIL R1 reset: actual=%b%b%b%b expected=1010", txd, tx_drive, buf_empty, tx_done);
    end
    @(negedge clk); rst_n = 1'b1;
    tick_on = 1'b1;
    // R11: write while closed is ignored
    put(8'h3C, 1'b0);
    #1; check("R11 closed write ignored", buf_empty, 1'b1);
    repeat (6) @(negedge clk);
    check("R11 line idle", txd, 1'b1);
    // enable, 8N1
    @(negedge clk); tx_enable = 1'b1; ie_empty = 1'b1; ie_done = 1'b1;
    put(8'hA5, 1'b0); drain();
    // R3 R4: 5 bits even, 6 bits odd, 7 bits two stop, reserved code
    frame_cfg(3'b000, 2'b10, 1'b0); put(8'h1B, 1'b0); drain();
    frame_cfg(3'b001, 2'b11, 1'b0); put(8'h2D, 1'b0); drain();
    frame_cfg(3'b010, 2'b00, 1'b1); put(8'h55, 1'b0); drain();
    frame_cfg(3'b101, 2'b01, 1'b0); put(8'hC3, 1'b0); drain();
    // R6: 9-bit frames with both ninth-bit values
    frame_cfg(3'b111, 2'b11, 1'b1); put(8'h0F, 1'b1); drain();
    frame_cfg(3'b111, 2'b10, 1'b0); put(8'hF0, 1'b0); drain();
    // R7: full buffer ignores a write (tick halted)
    frame_cfg(3'b011, 2'b10, 1'b0);
    @(negedge clk); tick_on = 1'b0;
    put(8'h81, 1'b0);
    put(8'h7E, 1'b0);
    #1; check("R7 still full after ignored write", buf_empty, 1'b0);
    @(negedge clk); tick_on = 1'b1; drain();
    // back-to-back queueing, interrupts masked part way
    put(8'h11, 1'b0); put(8'h22, 1'b0); put(8'h33, 1'b0);
    ie_empty = 1'b0;
    put(8'h44, 1'b0); put(8'h55, 1'b0);
    drain();
    ie_done = 1'b0; ie_empty = 1'b1;
    // R10: drop enable with two characters queued
    put(8'h96, 1'b0); put(8'h69, 1'b0);
    @(negedge clk); tx_enable = 1'b0;
    repeat (3) @(negedge clk);
    #1; check("R10 still driving while queued", tx_drive, 1'b1);
    drain();
    #1; check("R10 released after drain", tx_drive, 1'b0);
    check("R10 released line high", txd, 1'b1);
    put(8'hEE, 1'b0);
    #1; check("R11 write after release ignored", buf_empty, 1'b1);
    repeat (10) @(negedge clk);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule